// File: doc/BRIEF.md
# Tamper Monitor Security State Machine

This block tracks the security condition of an always-powered monitor. Two flags in its status register encode that condition. The non-valid flag is set by a battery power-on reset. The security-violation flag is set when a tamper event arrives and its enable bit is set. Together the flags give four conditions: valid, non-valid, failure, and non-valid plus failure. While either flag is set the block drives `haltCount` high, which freezes a companion time counter so that the moment of the event is kept. A security interrupt is raised while a violation is present and its enable bit is set.

Ten tamper sources arrive as single-cycle digital pulses. The recovery path depends on which lock bits are set. A soft lock on the tamper configuration is released by a system reset. A hard lock, and the failure-state hard lock, survive everything except a battery power-on reset. From failure alone, software cannot recover the unit. A system reset first moves it to non-valid plus failure, and only then does software clear the violation and the non-valid flag, in that order.

Software reaches the registers through a single select/write port. Reads return the selected register combinationally.

Top module: `tamper_guard`

## Requirements
- R1: While `batRstN` is low, and after it is released, the status register reads 0x00000002 (non-valid only), and the control, tamper-config and interrupt-enable registers read 0.
- R2: `haltCount` is high exactly when the violation flag (status bit 0) or the non-valid flag (status bit 1) is set.
- R3: A pulse on `evtPulse[i]` sets its status bit and the violation flag at the next edge, but only when tamper-config bit i is 1; a pulse on a disabled source is ignored. Source i in 0..7 maps to status bit 16+i, source 8 to status bit 2, and source 9 to status bit 3.
- R4: Writing 1 to an event status bit clears it. If a pulse on an enabled source arrives in the same cycle as the clear, the bit ends up set.
- R5: Writing 1 to status bit 0 clears the violation flag only if, before the write, the non-valid flag is set and no event status bit is set.
- R6: Writing 1 to status bit 1 clears the non-valid flag only if the violation flag is clear before the write.
- R7: In the control register, bit 16 (failure hard lock), bit 29 (config soft lock) and bit 30 (config hard lock) are set by writing 1. Writing 0 leaves them unchanged, and all other control bits read 0.
- R8: A write to the tamper-config register is ignored while control bit 29 or bit 30 is set.
- R9: A cycle with `sysRst` high clears control bit 29 and the interrupt enable, keeps bits 16 and 30, and ignores any register write in that cycle.
- R10: A cycle with `sysRst` high while the violation flag is set and the non-valid flag is clear sets the non-valid flag, unless control bit 16 is set, in which case the flags are unchanged.
- R11: `secIrq` is high exactly when the violation flag is set and interrupt-enable bit 0 is 1.
- R12: `regSel` selects the register: 0 control, 1 status, 2 tamper-config (bits 9:0), 3 interrupt-enable (bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| batRstN | input | 1 | Battery power-on reset, asynchronous, active low |
| sysRst | input | 1 | System reset request, synchronous, active high |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select for writes and reads |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the selected register |
| evtPulse | input | 10 | Tamper event pulses, one per source |
| haltCount | output | 1 | Freezes the companion counter |
| secIrq | output | 1 | Security-violation interrupt |

## Verification
The hardest condition to reach is non-valid plus failure when the unit did not start from a battery reset. The stimulus gets there by enabling the sources, firing an event, and clearing the event bits while the violation flag stays stuck, because the unit is in failure alone. It then applies a system reset with a write collided into the same cycle. The failure-state hard lock path is reached the same way, but with bit 16 set first. That run shows the system reset leaving the flags untouched, so that only a battery reset recovers the unit. A per-cycle behavioural model covers every register, `haltCount` and `secIrq` throughout.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int EVT_N  = 10;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 2;

  localparam int CTL_FAIL_HL = 16;
  localparam int CTL_CFG_SL  = 29;
  localparam int CTL_CFG_HL  = 30;
  localparam int ST_SVF      = 0;
  localparam int ST_NVF      = 1;
  localparam int IEN_SEC     = 0;
  localparam int LOCK_N      = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_IEN  = 2'd3
  } regSel_e;

  // status bit that records tamper source idx
  function automatic int evtStatusPos(input int idx);
    if (idx < 8) return 16 + idx;
    return idx - 6;
  endfunction

  typedef struct packed {
    logic              cfgLoad;
    logic              ienLoad;
    logic              ienClr;
    logic [LOCK_N-1:0] lockSet;   // {cfg hard, cfg soft, fail hard}
    logic              softUnlock;
    logic [EVT_N-1:0]  evtClr;
    logic              svfClr;
    logic              nvfClr;
    logic              nvfSet;
  } strobe_t;

  typedef struct packed {
    logic svf;
    logic nvf;
    logic evtAny;
    logic cfgSoftLock;
    logic cfgHardLock;
    logic failHardLock;
  } flags_t;
endpackage

// File: rtl/tg_ctrl.sv
module tg_ctrl
  import tg_pkg::*;
(
  input  logic              sysRst,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [DATA_W-1:0] wrData,
  input  flags_t            flags,
  output strobe_t           strobe
);
  logic unusedWr;
  assign unusedWr = ^wrData;

  logic              svfClrOk;
  logic              nvfClrOk;
  logic              cfgOpen;
  logic [EVT_N-1:0]  evtClrReq;

  // guards look only at the state before the write
  assign svfClrOk = flags.nvf & ~flags.evtAny;
  assign nvfClrOk = ~flags.svf;
  assign cfgOpen  = ~(flags.cfgSoftLock | flags.cfgHardLock);

  always_comb begin
    for (int i = 0; i < EVT_N; i++) evtClrReq[i] = wrData[evtStatusPos(i)];
  end

  always_comb begin
    strobe = '0;
    if (sysRst) begin
      strobe.softUnlock = 1'b1;
      strobe.ienClr     = 1'b1;
      strobe.nvfSet     = flags.svf & ~flags.nvf & ~flags.failHardLock;
    end else if (wrEn) begin
      case (regSel)
        SEL_CTRL: strobe.lockSet = {wrData[CTL_CFG_HL], wrData[CTL_CFG_SL], wrData[CTL_FAIL_HL]};
        SEL_STAT: begin
          strobe.evtClr = evtClrReq;
          strobe.svfClr = wrData[ST_SVF] & svfClrOk;
          strobe.nvfClr = wrData[ST_NVF] & nvfClrOk;
        end
        SEL_CFG:  strobe.cfgLoad = cfgOpen;
        SEL_IEN:  strobe.ienLoad = 1'b1;
        default:  strobe = '0;
      endcase
    end
  end
endmodule

// File: rtl/tg_datapath.sv
module tg_datapath
  import tg_pkg::*;
(
  input  logic              clk,
  input  logic              batRstN,
  input  strobe_t           strobe,
  input  logic [EVT_N-1:0]  cfgIn,
  input  logic              ienIn,
  input  logic [EVT_N-1:0]  evtPulse,
  input  logic [SEL_W-1:0]  regSel,
  output logic [DATA_W-1:0] rdData,
  output flags_t            flags,
  output logic [EVT_N-1:0]  cfgOut,
  output logic              haltCount,
  output logic              secIrq
);
  logic              svfQ, nvfQ, ienQ;
  logic              failHlQ, cfgSlQ, cfgHlQ;
  logic [EVT_N-1:0]  evtQ, cfgQ, evtHit;
  logic [DATA_W-1:0] statusVec, ctrlVec;

  assign evtHit = evtPulse & cfgQ;

  always_ff @(posedge clk or negedge batRstN) begin
    if (!batRstN) begin
      svfQ    <= 1'b0;
      nvfQ    <= 1'b1;
      evtQ    <= '0;
      cfgQ    <= '0;
      ienQ    <= 1'b0;
      failHlQ <= 1'b0;
      cfgSlQ  <= 1'b0;
      cfgHlQ  <= 1'b0;
    end else begin
      evtQ    <= (evtQ & ~strobe.evtClr) | evtHit;
      svfQ    <= (svfQ & ~strobe.svfClr) | (|evtHit);
      nvfQ    <= (nvfQ & ~strobe.nvfClr) | strobe.nvfSet;
      if (strobe.cfgLoad) cfgQ <= cfgIn;
      if (strobe.ienClr) ienQ <= 1'b0;
      else if (strobe.ienLoad) ienQ <= ienIn;
      failHlQ <= failHlQ | strobe.lockSet[0];
      cfgSlQ  <= (cfgSlQ | strobe.lockSet[1]) & ~strobe.softUnlock;
      cfgHlQ  <= cfgHlQ | strobe.lockSet[2];
    end
  end

  always_comb begin
    statusVec         = '0;
    statusVec[ST_SVF] = svfQ;
    statusVec[ST_NVF] = nvfQ;
    for (int i = 0; i < EVT_N; i++) statusVec[evtStatusPos(i)] = evtQ[i];
    ctrlVec              = '0;
    ctrlVec[CTL_FAIL_HL] = failHlQ;
    ctrlVec[CTL_CFG_SL]  = cfgSlQ;
    ctrlVec[CTL_CFG_HL]  = cfgHlQ;
  end

  always_comb begin
    case (regSel)
      SEL_CTRL: rdData = ctrlVec;
      SEL_STAT: rdData = statusVec;
      SEL_CFG:  rdData = {{(DATA_W-EVT_N){1'b0}}, cfgQ};
      default:  rdData = {{(DATA_W-1){1'b0}}, ienQ};
    endcase
  end

  assign flags = '{svf: svfQ, nvf: nvfQ, evtAny: |evtQ, cfgSoftLock: cfgSlQ,
                   cfgHardLock: cfgHlQ, failHardLock: failHlQ};
  assign cfgOut    = cfgQ;
  assign haltCount = svfQ | nvfQ;
  assign secIrq    = svfQ & ienQ;
endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
  import tg_pkg::*;
(
  input  logic              clk,
  input  logic              batRstN,
  input  logic              sysRst,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [EVT_N-1:0]  evtPulse,
  output logic              haltCount,
  output logic              secIrq
);
  strobe_t          strobe;
  flags_t           dpState;
  logic [EVT_N-1:0] cfgValue;

  tg_ctrl i_ctrl (
    .sysRst (sysRst),
    .wrEn   (wrEn),
    .regSel (regSel),
    .wrData (wrData),
    .flags  (dpState),
    .strobe (strobe)
  );

  tg_datapath i_dp (
    .clk       (clk),
    .batRstN   (batRstN),
    .strobe    (strobe),
    .cfgIn     (wrData[EVT_N-1:0]),
    .ienIn     (wrData[IEN_SEC]),
    .evtPulse  (evtPulse),
    .regSel    (regSel),
    .rdData    (rdData),
    .flags     (dpState),
    .cfgOut    (cfgValue),
    .haltCount (haltCount),
    .secIrq    (secIrq)
  );
endmodule

// File: rtl/tamper_guard_chk.sv
module tamper_guard_chk
  import tg_pkg::*;
(
  input logic             clk,
  input logic             batRstN,
  input logic             sysRst,
  input logic [EVT_N-1:0] evtPulse,
  input flags_t           st,
  input logic [EVT_N-1:0] cfg
);
  AST_EVT_SETS_SVF: assert property (@(posedge clk) disable iff (!batRstN)
    (|(evtPulse & cfg)) |=> st.svf); // R3
  AST_SVF_CLR_GUARD: assert property (@(posedge clk) disable iff (!batRstN)
    $fell(st.svf) |-> ($past(st.nvf) && !$past(st.evtAny))); // R5
  AST_NVF_CLR_GUARD: assert property (@(posedge clk) disable iff (!batRstN)
    $fell(st.nvf) |-> !$past(st.svf)); // R6
  AST_CFG_HARD_STICKY: assert property (@(posedge clk) disable iff (!batRstN)
    st.cfgHardLock |=> st.cfgHardLock); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!batRstN)
    (st.cfgSoftLock || st.cfgHardLock) |=> $stable(cfg)); // R8
  AST_SYSRST_TO_NVF: assert property (@(posedge clk) disable iff (!batRstN)
    (sysRst && st.svf && !st.nvf && !st.failHardLock) |=> st.nvf); // R10
  AST_FAIL_HL_BLOCKS: assert property (@(posedge clk) disable iff (!batRstN)
    (sysRst && st.svf && !st.nvf && st.failHardLock) |=> !st.nvf); // R10
endmodule

bind tamper_guard tamper_guard_chk i_tamper_guard_chk (
  .clk      (clk),
  .batRstN  (batRstN),
  .sysRst   (sysRst),
  .evtPulse (evtPulse),
  .st       (dpState),
  .cfg      (cfgValue)
);

// File: tb/test_tamper_guard.sv
`timescale 1ns/1ps
module test_tamper_guard;
  logic        clk = 1'b0;
  logic        batRstN = 1'b0;
  logic        sysRst = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [9:0]  evtPulse = '0;
  logic        haltCount, secIrq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tamper_guard i_tamper_guard (
    .clk(clk), .batRstN(batRstN), .sysRst(sysRst), .wrEn(wrEn), .regSel(regSel),
    .wrData(wrData), .rdData(rdData), .evtPulse(evtPulse),
    .haltCount(haltCount), .secIrq(secIrq)
  );

  // behavioural reference model
  bit       mSvf, mNvf, mIen, mFhl, mCsl, mChl;
  bit [9:0] mEvt, mCfg, hitV, evtOld;
  bit       svfOld, nvfOld;

  function automatic int statPos(input int k);
    return (k < 8) ? (16 + k) : (k - 6);
  endfunction

  function automatic logic [31:0] modelRead(input logic [1:0] sel);
    logic [31:0] v;
    v = '0;
    case (sel)
      2'd0: begin v[16] = mFhl; v[29] = mCsl; v[30] = mChl; end
      2'd1: begin
        v[0] = mSvf; v[1] = mNvf;
        for (int k = 0; k < 10; k++) v[statPos(k)] = mEvt[k];
      end
      2'd2: v[9:0] = mCfg;
      default: v[0] = mIen;
    endcase
    return v;
  endfunction

  always @(posedge clk or negedge batRstN) begin
    if (!batRstN) begin
      mSvf = 0; mNvf = 1; mIen = 0; mFhl = 0; mCsl = 0; mChl = 0; mEvt = '0; mCfg = '0;
    end else begin
      hitV = evtPulse & mCfg;
      svfOld = mSvf; nvfOld = mNvf; evtOld = mEvt;
      if (sysRst) begin
        mCsl = 0; mIen = 0;
        if (svfOld && !nvfOld && !mFhl) mNvf = 1;
      end else if (wrEn) begin
        case (regSel)
          2'd0: begin
            if (wrData[16]) mFhl = 1;
            if (wrData[29]) mCsl = 1;
            if (wrData[30]) mChl = 1;
          end
          2'd1: begin
            for (int k = 0; k < 10; k++) if (wrData[statPos(k)]) mEvt[k] = 0;
            if (wrData[0] && nvfOld && evtOld == 0) mSvf = 0;
            if (wrData[1] && !svfOld) mNvf = 0;
          end
          2'd2: if (!mCsl && !mChl) mCfg = wrData[9:0];
          default: mIen = wrData[0];
        endcase
      end
      mEvt = mEvt | hitV;
      if (hitV != 0) mSvf = 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (batRstN && !done) begin
      chk("R2 per-cycle haltCount", {31'b0, haltCount}, {31'b0, mSvf | mNvf});
      chk("R11 per-cycle secIrq", {31'b0, secIrq}, {31'b0, mSvf & mIen});
      chk("R12 per-cycle rdData", rdData, modelRead(regSel));
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); wrEn = 1; regSel = sel; wrData = d;
    @(negedge clk); wrEn = 0; wrData = '0;
  endtask

  task automatic wrEvt(input logic [1:0] sel, input logic [31:0] d, input logic [9:0] e);
    @(negedge clk); wrEn = 1; regSel = sel; wrData = d; evtPulse = e;
    @(negedge clk); wrEn = 0; wrData = '0; evtPulse = '0;
  endtask

  task automatic pulse(input logic [9:0] e);
    @(negedge clk); evtPulse = e;
    @(negedge clk); evtPulse = '0;
  endtask

  task automatic sysReset(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); sysRst = 1; wrEn = 1; regSel = sel; wrData = d;
    @(negedge clk); sysRst = 0; wrEn = 0; wrData = '0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [31:0] exp, input string req);
    @(negedge clk); regSel = sel; #1;
    chk(req, rdData, exp);
  endtask

  task automatic pins(input logic expHalt, input logic expIrq, input string req);
    @(negedge clk); #1;
    chk({req, " haltCount"}, {31'b0, haltCount}, {31'b0, expHalt});
    chk({req, " secIrq"}, {31'b0, secIrq}, {31'b0, expIrq});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 run incomplete actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    regSel = 2'd1; #1;
    chk("R1 status in reset", rdData, 32'h2);
    batRstN = 1;
    rd(2'd1, 32'h0000_0002, "R1 status after reset");
    rd(2'd0, 32'h0, "R1 ctrl after reset");
    rd(2'd2, 32'h0, "R1 cfg after reset");
    rd(2'd3, 32'h0, "R1 ien after reset");
    pins(1, 0, "R1 R2 reset");

    wr(2'd1, 32'h2);                                  // R6: clear non-valid
    rd(2'd1, 32'h0, "R6 nvf cleared when svf clear");
    pins(0, 0, "R2 valid");

    pulse(10'h001);                                   // R3: disabled source
    rd(2'd1, 32'h0, "R3 disabled event ignored");

    wr(2'd2, 32'h3FF);
    rd(2'd2, 32'h3FF, "R12 cfg readback");
    wr(2'd3, 32'h1);
    pulse(10'h020);                                   // source 5 -> bit 21
    rd(2'd1, 32'h0020_0001, "R3 enabled event sets bit and svf");
    pins(1, 1, "R2 R11 failure");

    wr(2'd1, 32'h1);
    rd(2'd1, 32'h0020_0001, "R5 svf held while events set");
    wr(2'd1, 32'h0020_0001);
    rd(2'd1, 32'h0000_0001, "R5 same-write svf clear refused");
    wr(2'd1, 32'h1);
    rd(2'd1, 32'h0000_0001, "R5 svf held in failure alone");

    wr(2'd0, 32'h2000_0000);
    rd(2'd0, 32'h2000_0000, "R7 soft lock set");
    wr(2'd2, 32'h0);
    rd(2'd2, 32'h3FF, "R8 cfg write refused under soft lock");
    wr(2'd0, 32'h0);
    rd(2'd0, 32'h2000_0000, "R7 zero write keeps lock");

    sysReset(2'd0, 32'h0001_0000);                     // write collides, ignored
    rd(2'd0, 32'h0, "R9 soft lock cleared, write ignored");
    rd(2'd1, 32'h0000_0003, "R10 failure to non-valid plus failure");
    rd(2'd3, 32'h0, "R9 ien cleared");
    pins(1, 0, "R11 irq off after ien clear");

    wr(2'd1, 32'h2);
    rd(2'd1, 32'h0000_0003, "R6 nvf clear refused while svf set");
    wr(2'd2, 32'h0);
    rd(2'd2, 32'h0, "R8 cfg write accepted when unlocked");
    wr(2'd1, 32'h1);
    rd(2'd1, 32'h0000_0002, "R5 svf cleared in non-valid");
    wr(2'd1, 32'h2);
    rd(2'd1, 32'h0, "R6 back to valid");
    pins(0, 0, "R2 recovered");

    wr(2'd2, 32'h300);
    pulse(10'h301);
    rd(2'd1, 32'h0000_000D, "R3 overflow sources map to bits 2 and 3");
    wrEvt(2'd1, 32'h0000_000C, 10'h100);
    rd(2'd1, 32'h0000_0005, "R4 set wins over clear");

    wr(2'd0, 32'h0001_0000);
    rd(2'd0, 32'h0001_0000, "R7 failure hard lock set");
    sysReset(2'd3, 32'h1);
    rd(2'd1, 32'h0000_0005, "R10 failure hard lock blocks transition");
    rd(2'd3, 32'h0, "R9 ien write ignored during sysRst");

    wr(2'd0, 32'h4000_0000);
    sysReset(2'd2, 32'h0);
    rd(2'd0, 32'h4001_0000, "R9 hard locks kept by sysRst");
    wr(2'd2, 32'h0);
    rd(2'd2, 32'h300, "R8 cfg write refused under hard lock");

    @(negedge clk); batRstN = 0;
    @(negedge clk); batRstN = 1;
    rd(2'd0, 32'h0, "R1 battery reset clears locks");
    rd(2'd1, 32'h0000_0002, "R1 battery reset non-valid");
    rd(2'd2, 32'h0, "R1 battery reset cfg");

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule